// File: doc/BRIEF.md
# Clock Generator Fault Supervisor

This block watches over a clock generator that runs in one of four operating modes: self-clocked, locked loop on an internal reference, bypass on an external reference, and locked loop on an external reference. Lock indications and "clock too slow" indications arrive as inputs. The analog loop and the frequency detectors are outside the block. From these inputs the supervisor keeps two sticky fault flags: lock lost and clock lost. It decides which clocks are worth monitoring in the present mode and reports an external-reference health bit. On a clock failure it moves the generator to a safer mode by itself.

Some lock losses are announced by the block's own inputs: a multiplier write, a clock-select change, a trim write in internal locked mode, or a planned stop. These drop the lock indication without raising a fault. A lock that falls with none of these causes is a fault. Software clears a flag by reading the status and then writing a one to the clear strobe. Each flag either raises the interrupt or, when its reset-enable input is high, issues a one-cycle reset request.

Top module: `clkgen_fault_sup`

## Requirements
- R1: After reset, clock select and clock status are 00, and every other output is 0: lock, off, reference-ok, both flags, interrupt and reset request.
- R2: Clock status encodes the mode as 00 self-clocked, 01 internal locked, 10 bypass and 11 external locked. It follows clock select one cycle after a write. A select with bit 1 set is entered only while `ref_up` is 1. Without it, status stays 00 or 01 if it already holds one of those, and otherwise becomes 00.
- R3: In a locked mode (status bit 0 set), `lock_o` repeats `lock_in` one cycle later. A fall of `lock_in` while `lock_o` is 1 and no masking cause is present sets the lock-lost flag.
- R4: A multiplier write, a clock-select write that changes the value, or a trim write in mode 01 clears `lock_o` without setting the lock-lost flag. `lock_o` then stays 0 until `lock_in` has been seen low.
- R5: A stop with debug-enable and oscillator-stop-enable both 0 sets `off_o` and clears `lock_o`, and leaves the lock-lost flag unchanged. If the block reaches the off state during a stop without having planned it (debug-enable dropped while stopped), the wake sets the lock-lost flag.
- R6: The clock-lost flag sets on a slow pulse from a clock that is monitored. Monitoring by state:
  - Off: only the reference is monitored, and only when select is 10 with `ref_type` 1.
  - Mode 00: the oscillator is monitored; the reference is monitored when select is 11, or when select is 10 with `ref_type` 1.
  - Mode 01: the oscillator is monitored; the reference is monitored only when select is 11.
  - Mode 10: only the reference is monitored.
  - Mode 11: both clocks are monitored.
- R7: `ref_ok` is 1 in mode 00 with select 10 and `ref_type` 0. Otherwise it is the inverse of `ref_slow` when the reference is monitored, and 0 when it is not. It is registered.
- R8: In mode 11, reference loss moves status and select to 00, and oscillator loss moves them to 10. In mode 10, reference loss moves them to 00.
- R9: A clock loss while status is 01 or 11 also sets the lock-lost flag.
- R10: A clear write lowers a flag only after a status read made while that flag was set. A set event in the same cycle wins over the clear and withdraws the earlier read.
- R11: `irq` is the OR of each flag gated by the inverse of its reset-enable input.
- R12: A flag that sets while its reset-enable is 1 produces a one-cycle `rst_req`. In the following cycle that request clears both flags.
- R13: A clock-select write in the same cycle as an automatic fallback is ignored.
- R14: With lock-lost reset enabled and clock-lost reset disabled, a clock loss in a locked mode yields a reset request with `irq` held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Lock indication from the locked loop |
| ref_slow | input | 1 | Pulse: external reference below minimum frequency |
| osc_slow | input | 1 | Pulse: loop oscillator below minimum frequency |
| ref_up | input | 1 | External reference has started and may be selected |
| ref_type | input | 1 | Reference-type bit used in the monitoring rules |
| sel_wr | input | 1 | Clock-select write strobe |
| sel_wdata | input | SEL_W | Clock-select write value |
| mult_wr | input | 1 | Multiplier write strobe |
| trim_wr | input | 1 | Trim write strobe |
| stat_rd | input | 1 | Status read strobe |
| flag_clr_wr | input | 1 | Write-one-to-clear strobe for the flags |
| lock_lost_rst_en | input | 1 | Lock-lost flag issues a reset instead of an interrupt |
| clk_lost_rst_en | input | 1 | Clock-lost flag issues a reset instead of an interrupt |
| stop_in | input | 1 | Stop request pulse |
| wake_in | input | 1 | Wake pulse |
| dbg_en | input | 1 | Debug enable, keeps clocks during stop |
| osc_stop_en | input | 1 | Oscillator kept running during stop |
| sel_o | output | SEL_W | Current clock select |
| mode_o | output | SEL_W | Clock status (current mode) |
| lock_o | output | 1 | Qualified lock indication |
| off_o | output | 1 | Generator in off state |
| ref_ok | output | 1 | External reference status |
| lock_lost_flag | output | 1 | Sticky lock-lost flag |
| clk_lost_flag | output | 1 | Sticky clock-lost flag |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Every result of this block is registered. A strobe or level applied in one cycle shows up at the outputs after the next rising edge: mode, select, lock, flags, reset request, off state and reference status are all due then. The interrupt follows in the same cycle as the flag it derives from. The one exception is the flag clear caused by a reset request, which lands one edge after the request. The bench drives inputs shortly after a rising edge, pushes the values due after the next edge into the scoreboard, and compares them on the falling edge that follows that edge. In this way every check falls exactly on the cycle where the requirement puts the result.

// File: rtl/clksup_pkg.sv
package clksup_pkg;
   localparam logic [1:0] MODE_SELF     = 2'b00;
   localparam logic [1:0] MODE_INT_LOCK = 2'b01;
   localparam logic [1:0] MODE_BYPASS   = 2'b10;
   localparam logic [1:0] MODE_EXT_LOCK = 2'b11;

   localparam int FLAG_LOCK = 0;
   localparam int FLAG_CLK  = 1;
   localparam int NUM_FLAGS = 2;

   function automatic logic mode_is_locked(input logic [1:0] m);
      return m[0];
   endfunction
endpackage

// File: rtl/clksup_monitor.sv
module clksup_monitor
   import clksup_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0] mode,
   input  logic [SEL_W-1:0] sel,
   input  logic             ref_type,
   input  logic             off,
   input  logic             ref_slow,
   input  logic             osc_slow,
   output logic             ref_loss,
   output logic             osc_loss,
   output logic             ref_ok_d
);
   logic mon_ref, mon_osc, force_hi;

   always_comb begin
      mon_ref  = 1'b0;
      mon_osc  = 1'b0;
      force_hi = 1'b0;
      if (off) begin
         mon_ref = (sel == MODE_BYPASS) && ref_type;
      end else begin
         case (mode)
            MODE_SELF: begin
               mon_osc  = 1'b1;
               mon_ref  = ((sel == MODE_BYPASS) && ref_type) || (sel == MODE_EXT_LOCK);
               force_hi = (sel == MODE_BYPASS) && !ref_type;
            end
            MODE_INT_LOCK: begin
               mon_osc = 1'b1;
               mon_ref = (sel == MODE_EXT_LOCK);
            end
            MODE_BYPASS: mon_ref = 1'b1;
            default: begin
               mon_ref = 1'b1;
               mon_osc = 1'b1;
            end
         endcase
      end
   end

   assign ref_loss = mon_ref & ref_slow;
   assign osc_loss = mon_osc & osc_slow;
   assign ref_ok_d = force_hi | (mon_ref & ~ref_slow);
endmodule

// File: rtl/clksup_mode_ctl.sv
module clksup_mode_ctl
   import clksup_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic             ref_up,
   input  logic             ref_loss,
   input  logic             osc_loss,
   output logic [SEL_W-1:0] sel_q,
   output logic [SEL_W-1:0] mode_q,
   output logic             sel_change
);
   logic             fallback, sel_acc;
   logic [SEL_W-1:0] fb_mode, sel_nxt, mode_nxt;

   always_comb begin
      fallback = 1'b0;
      fb_mode  = MODE_SELF;
      if (mode_q == MODE_EXT_LOCK && ref_loss) begin
         fallback = 1'b1;
         fb_mode  = MODE_SELF;
      end else if (mode_q == MODE_EXT_LOCK && osc_loss) begin
         fallback = 1'b1;
         fb_mode  = MODE_BYPASS;
      end else if (mode_q == MODE_BYPASS && ref_loss) begin
         fallback = 1'b1;
         fb_mode  = MODE_SELF;
      end
   end

   assign sel_acc    = sel_wr & ~fallback;
   assign sel_change = sel_acc & (sel_wdata != sel_q);

   always_comb begin
      if (fallback)      sel_nxt = fb_mode;
      else if (sel_acc)  sel_nxt = sel_wdata;
      else               sel_nxt = sel_q;

      if (fallback)           mode_nxt = fb_mode;
      else if (!sel_nxt[1])   mode_nxt = sel_nxt;
      else if (ref_up)        mode_nxt = sel_nxt;
      else if (mode_q[1])     mode_nxt = MODE_SELF;
      else                    mode_nxt = mode_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= MODE_SELF;
         mode_q <= MODE_SELF;
      end else begin
         sel_q  <= sel_nxt;
         mode_q <= mode_nxt;
      end
   end
endmodule

// File: rtl/clksup_lock_trk.sv
module clksup_lock_trk
   import clksup_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] mode,
   input  logic             lock_in,
   input  logic             exp_evt,
   input  logic             loc_evt,
   input  logic             stop_in,
   input  logic             wake_in,
   input  logic             dbg_en,
   input  logic             osc_stop_en,
   output logic             lock_q,
   output logic             off_q,
   output logic             lol_evt
);
   logic stopped, planned, holdoff;
   logic stop_go, wake_go, stopped_nxt, off_nxt, mask, unexp_fall, wake_lol;

   assign stop_go     = stop_in & ~stopped;
   assign wake_go     = wake_in & stopped & ~stop_in;
   assign stopped_nxt = stop_go ? 1'b1 : (wake_go ? 1'b0 : stopped);
   assign off_nxt     = stopped_nxt & ~dbg_en & ~osc_stop_en;
   assign wake_lol    = wake_go & off_q & ~planned;

   assign mask = exp_evt | loc_evt | holdoff | off_q | off_nxt | ~mode_is_locked(mode);
   assign unexp_fall = lock_q & ~lock_in & ~mask;
   assign lol_evt    = unexp_fall | wake_lol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stopped <= 1'b0;
         planned <= 1'b0;
         off_q   <= 1'b0;
         holdoff <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         stopped <= stopped_nxt;
         off_q   <= off_nxt;
         if (stop_go) planned <= ~dbg_en & ~osc_stop_en;
         if (exp_evt)       holdoff <= 1'b1;
         else if (!lock_in) holdoff <= 1'b0;
         lock_q <= lock_in & ~mask;
      end
   end
endmodule

// File: rtl/clksup_sticky_flag.sv
module clksup_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic rd,
   input  logic clr_wr,
   input  logic rst_en,
   input  logic ind_rst,
   output logic flag_q
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         armed  <= 1'b0;
      end else if (ind_rst) begin
         flag_q <= 1'b0;
         armed  <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
         armed  <= 1'b0;
      end else if (clr_wr && armed && !rst_en) begin
         flag_q <= 1'b0;
         armed  <= 1'b0;
      end else if (rd && flag_q) begin
         armed  <= 1'b1;
      end
   end
endmodule

// File: rtl/clkgen_fault_sup.sv
module clkgen_fault_sup
   import clksup_pkg::*;
#(
   parameter int SEL_W      = 2,
   parameter bit REF_OK_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_in,
   input  logic             ref_slow,
   input  logic             osc_slow,
   input  logic             ref_up,
   input  logic             ref_type,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic             mult_wr,
   input  logic             trim_wr,
   input  logic             stat_rd,
   input  logic             flag_clr_wr,
   input  logic             lock_lost_rst_en,
   input  logic             clk_lost_rst_en,
   input  logic             stop_in,
   input  logic             wake_in,
   input  logic             dbg_en,
   input  logic             osc_stop_en,
   output logic [SEL_W-1:0] sel_o,
   output logic [SEL_W-1:0] mode_o,
   output logic             lock_o,
   output logic             off_o,
   output logic             ref_ok,
   output logic             lock_lost_flag,
   output logic             clk_lost_flag,
   output logic             irq,
   output logic             rst_req
);
   if (SEL_W != 2) begin : g_bad_sel_w
      $error("clkgen_fault_sup: SEL_W must be 2, the mode encoding depends on it");
   end

   logic ref_loss, osc_loss, ref_ok_d, sel_change, exp_evt, loc_evt, lol_evt;
   logic [NUM_FLAGS-1:0] set_v, rst_en_v, flag_v;
   logic rst_req_q;

   clksup_monitor #(.SEL_W(SEL_W)) u_mon (
      .mode(mode_o), .sel(sel_o), .ref_type(ref_type), .off(off_o),
      .ref_slow(ref_slow), .osc_slow(osc_slow),
      .ref_loss(ref_loss), .osc_loss(osc_loss), .ref_ok_d(ref_ok_d)
   );

   clksup_mode_ctl #(.SEL_W(SEL_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
      .ref_up(ref_up), .ref_loss(ref_loss), .osc_loss(osc_loss),
      .sel_q(sel_o), .mode_q(mode_o), .sel_change(sel_change)
   );

   assign loc_evt = ref_loss | osc_loss;
   assign exp_evt = mult_wr | sel_change | (trim_wr & (mode_o == MODE_INT_LOCK));

   clksup_lock_trk #(.SEL_W(SEL_W)) u_lock (
      .clk(clk), .rst_n(rst_n), .mode(mode_o), .lock_in(lock_in),
      .exp_evt(exp_evt), .loc_evt(loc_evt), .stop_in(stop_in), .wake_in(wake_in),
      .dbg_en(dbg_en), .osc_stop_en(osc_stop_en),
      .lock_q(lock_o), .off_q(off_o), .lol_evt(lol_evt)
   );

   assign set_v[FLAG_LOCK]    = lol_evt | (loc_evt & mode_is_locked(mode_o) & ~off_o);
   assign set_v[FLAG_CLK]     = loc_evt;
   assign rst_en_v[FLAG_LOCK] = lock_lost_rst_en;
   assign rst_en_v[FLAG_CLK]  = clk_lost_rst_en;

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      clksup_sticky_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set(set_v[i]), .rd(stat_rd),
         .clr_wr(flag_clr_wr), .rst_en(rst_en_v[i]), .ind_rst(rst_req_q),
         .flag_q(flag_v[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req_q <= 1'b0;
      else        rst_req_q <= (|(set_v & rst_en_v)) & ~rst_req_q;
   end

   if (REF_OK_REG) begin : g_ref_ok_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ref_ok <= 1'b0;
         else        ref_ok <= ref_ok_d;
      end
   end else begin : g_ref_ok_comb
      assign ref_ok = ref_ok_d;
   end

   assign lock_lost_flag = flag_v[FLAG_LOCK];
   assign clk_lost_flag  = flag_v[FLAG_CLK];
   assign rst_req        = rst_req_q;
   assign irq            = (|(flag_v & ~rst_en_v)) & ~rst_req_q;
endmodule

// File: rtl/clksup_checker.sv
module clksup_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_slow,
   input logic       osc_slow,
   input logic       flag_clr_wr,
   input logic [1:0] mode_o,
   input logic [1:0] sel_o,
   input logic       lock_o,
   input logic       off_o,
   input logic       lock_lost_flag,
   input logic       clk_lost_flag,
   input logic       irq,
   input logic       rst_req
);
   assert_rst_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_rst_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (!lock_lost_flag && !clk_lost_flag));

   assert_irq_masked_R14: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !irq);

   assert_off_no_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      off_o |-> !lock_o);

   assert_lock_in_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> ($past(mode_o) == 2'b01 || $past(mode_o) == 2'b11));

   assert_ext_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b11 && !off_o && ref_slow) |=> (mode_o == 2'b00 && sel_o == 2'b00));

   assert_osc_loss_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && !off_o && osc_slow && !rst_req) |=> clk_lost_flag);

   assert_lock_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_lost_flag && !flag_clr_wr && !rst_req) |=> lock_lost_flag);
endmodule

bind clkgen_fault_sup clksup_checker u_chk (
   .clk(clk), .rst_n(rst_n), .ref_slow(ref_slow), .osc_slow(osc_slow),
   .flag_clr_wr(flag_clr_wr), .mode_o(mode_o), .sel_o(sel_o), .lock_o(lock_o),
   .off_o(off_o), .lock_lost_flag(lock_lost_flag), .clk_lost_flag(clk_lost_flag),
   .irq(irq), .rst_req(rst_req)
);

// File: tb/tb_clkgen_fault_sup.sv
`timescale 1ns/1ps
module tb_clkgen_fault_sup;
   localparam int S_MODE = 0, S_SEL = 1, S_LOCK = 2, S_OFF = 3, S_REFOK = 4,
                  S_LOL = 5, S_LOC = 6, S_IRQ = 7, S_RST = 8;

   typedef struct {
      int         sig;
      logic [1:0] val;
      string      tag;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lock_in = 0, ref_slow = 0, osc_slow = 0, ref_up = 0, ref_type = 0;
   logic sel_wr = 0, mult_wr = 0, trim_wr = 0, stat_rd = 0, flag_clr_wr = 0;
   logic lock_lost_rst_en = 0, clk_lost_rst_en = 0;
   logic stop_in = 0, wake_in = 0, dbg_en = 0, osc_stop_en = 0;
   logic [1:0] sel_wdata = 2'b00;
   logic [1:0] sel_o, mode_o;
   logic lock_o, off_o, ref_ok, lock_lost_flag, clk_lost_flag, irq, rst_req;

   exp_t exp_q[$];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   clkgen_fault_sup dut (.*);

   function automatic logic [1:0] get_sig(int s);
      case (s)
         S_MODE:  return mode_o;
         S_SEL:   return sel_o;
         S_LOCK:  return {1'b0, lock_o};
         S_OFF:   return {1'b0, off_o};
         S_REFOK: return {1'b0, ref_ok};
         S_LOL:   return {1'b0, lock_lost_flag};
         S_LOC:   return {1'b0, clk_lost_flag};
         S_IRQ:   return {1'b0, irq};
         default: return {1'b0, rst_req};
      endcase
   endfunction

   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         exp_t it;
         logic [1:0] act;
         it  = exp_q.pop_front();
         act = get_sig(it.sig);
         n_chk++;
         if (act !== it.val) begin
            n_fail++;
            $display("FAIL %s: signal %0d actual %0b expected %0b", it.tag, it.sig, act, it.val);
         end
      end
   end

   task automatic want(int sig, logic [1:0] val, string tag);
      exp_t it;
      it.sig = sig; it.val = val; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic tick();
      @(posedge clk); #1;
      sel_wr = 0; mult_wr = 0; trim_wr = 0; stat_rd = 0; flag_clr_wr = 0;
      ref_slow = 0; osc_slow = 0; stop_in = 0; wake_in = 0;
   endtask

   task automatic clear_flags();
      stat_rd = 1; tick();
      flag_clr_wr = 1; tick();
   endtask

   task automatic write_sel(logic [1:0] v);
      sel_wdata = v; sel_wr = 1; tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      want(S_MODE, 0, "R1"); want(S_SEL, 0, "R1"); want(S_LOCK, 0, "R1");
      want(S_OFF, 0, "R1"); want(S_REFOK, 0, "R1"); want(S_LOL, 0, "R1");
      want(S_LOC, 0, "R1"); want(S_IRQ, 0, "R1"); want(S_RST, 0, "R1");
      // R2 enter internal locked mode
      write_sel(2'b01);
      want(S_SEL, 1, "R2"); want(S_MODE, 1, "R2"); want(S_LOCK, 0, "R2");
      tick();
      lock_in = 1; tick(); want(S_LOCK, 1, "R3");
      lock_in = 0; tick();
      want(S_LOCK, 0, "R3"); want(S_LOL, 1, "R3"); want(S_IRQ, 1, "R11");
      // R10 clear needs a prior read
      flag_clr_wr = 1; tick(); want(S_LOL, 1, "R10");
      stat_rd = 1; tick(); want(S_LOL, 1, "R10");
      flag_clr_wr = 1; tick(); want(S_LOL, 0, "R10"); want(S_IRQ, 0, "R11");
      // R4 expected losses
      lock_in = 1; tick();
      mult_wr = 1; tick(); want(S_LOCK, 0, "R4"); want(S_LOL, 0, "R4");
      tick(); want(S_LOCK, 0, "R4");
      lock_in = 0; tick(); want(S_LOL, 0, "R4");
      lock_in = 1; tick(); want(S_LOCK, 1, "R4");
      trim_wr = 1; tick(); want(S_LOCK, 0, "R4"); want(S_LOL, 0, "R4");
      lock_in = 0; tick();
      lock_in = 1; tick(); want(S_LOCK, 1, "R4");
      // R6 reference not monitored in mode 01 with select 01
      ref_slow = 1; tick(); want(S_LOC, 0, "R6");
      // R6 R9 oscillator loss in locked mode
      osc_slow = 1; tick();
      want(S_LOC, 1, "R6"); want(S_LOL, 1, "R9"); want(S_LOCK, 0, "R9");
      want(S_MODE, 1, "R8"); want(S_IRQ, 1, "R11");
      clear_flags(); want(S_LOC, 0, "R10"); want(S_LOL, 0, "R10");
      // R10 set wins over clear
      osc_slow = 1; tick();
      stat_rd = 1; tick();
      flag_clr_wr = 1; osc_slow = 1; tick(); want(S_LOC, 1, "R10");
      flag_clr_wr = 1; tick(); want(S_LOC, 1, "R10");
      clear_flags(); want(S_LOC, 0, "R10");
      // back to self-clocked, lock drop masked by the select change
      lock_in = 0; write_sel(2'b00); want(S_MODE, 0, "R2"); want(S_LOL, 0, "R4");
      // R2 R7 select 10 without reference up
      write_sel(2'b10); want(S_SEL, 2, "R2"); want(S_MODE, 0, "R2");
      tick(); want(S_REFOK, 1, "R7");
      ref_slow = 1; tick(); want(S_LOC, 0, "R6"); want(S_REFOK, 1, "R7");
      ref_type = 1; tick(); want(S_REFOK, 1, "R7");
      ref_slow = 1; tick();
      want(S_LOC, 1, "R6"); want(S_REFOK, 0, "R7"); want(S_LOL, 0, "R9");
      clear_flags();
      // R2 R8 bypass and fallback
      ref_up = 1; tick(); want(S_MODE, 2, "R2");
      ref_slow = 1; tick();
      want(S_MODE, 0, "R8"); want(S_SEL, 0, "R8"); want(S_LOC, 1, "R6");
      clear_flags();
      write_sel(2'b11); want(S_MODE, 3, "R2"); want(S_SEL, 3, "R2");
      tick();
      osc_slow = 1; tick();
      want(S_MODE, 2, "R8"); want(S_SEL, 2, "R8"); want(S_LOC, 1, "R8"); want(S_LOL, 1, "R9");
      clear_flags();
      write_sel(2'b11); want(S_MODE, 3, "R2");
      // R13 write ignored during fallback
      ref_slow = 1; sel_wdata = 2'b01; sel_wr = 1; tick();
      want(S_MODE, 0, "R13"); want(S_SEL, 0, "R13");
      clear_flags();
      ref_up = 0; ref_type = 0;
      // R12 R14 reset request overrides clock-loss interrupt
      lock_lost_rst_en = 1;
      write_sel(2'b01); tick();
      osc_slow = 1; tick();
      want(S_RST, 1, "R12"); want(S_IRQ, 0, "R14"); want(S_LOC, 1, "R14"); want(S_LOL, 1, "R12");
      tick();
      want(S_RST, 0, "R12"); want(S_LOC, 0, "R12"); want(S_LOL, 0, "R12"); want(S_IRQ, 0, "R14");
      lock_lost_rst_en = 0;
      // R5 planned stop
      lock_in = 1; tick(); want(S_LOCK, 1, "R3");
      stop_in = 1; tick(); want(S_OFF, 1, "R5"); want(S_LOCK, 0, "R5"); want(S_LOL, 0, "R5");
      osc_slow = 1; tick(); want(S_LOC, 0, "R6");
      wake_in = 1; tick(); want(S_OFF, 0, "R5"); want(S_LOL, 0, "R5");
      tick(); want(S_LOCK, 1, "R3");
      // R5 unplanned off
      dbg_en = 1; stop_in = 1; tick(); want(S_OFF, 0, "R5"); want(S_LOCK, 1, "R5");
      dbg_en = 0; tick(); want(S_OFF, 1, "R5"); want(S_LOL, 0, "R5");
      wake_in = 1; tick(); want(S_OFF, 0, "R5"); want(S_LOL, 1, "R5"); want(S_IRQ, 1, "R11");
      clear_flags(); want(S_LOL, 0, "R10");
      @(negedge clk); #1;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule